// File: doc/BRIEF.md
# Strobe-Captured Message Buffer

The block sits next to an external processor and logs every byte the processor writes to one dedicated I/O port. The port's select line is active low. The block brings each falling edge of that line into its own clock domain. On each edge it stores the byte on the processor data bus into a local circular buffer. The processor is never stalled, and nothing tells it when the buffer is full.

A local consumer pulls bytes out one at a time through a request/response pair. Each response tells the consumer whether a byte was available.

The processor keeps a small header in its own memory. The byte at `base - 1` holds the consumer's read index. After each byte is taken, the block asks an external bus master to write the new read index into that byte, so the processor can tell how far the consumer has got. An initialisation command makes the two indices agree. It copies the processor's write index, found at `base - 2`, into `base - 1`, and then records `base`. While the recorded base is zero, the block makes no memory accesses after reads.

A new initialisation is accepted only while no bus-master transaction is outstanding.

Top module: `iostrobe_msgbuf`

## Requirements
- R1: After reset, `rd_done` and `mst_req` are low, and the first read reports no data (`rd_valid` = 0).
- R2: Each high-to-low transition of `io_sel_n` stores the byte on `io_data` exactly once. A select held low for many cycles stores one byte. `io_data` must stay stable for at least four clock cycles after the select falls.
- R3: In the cycle after `rd_req` is sampled high, `rd_done` is high for one cycle. If no byte is waiting, `rd_valid` is 0 and the read index does not move.
- R4: When a byte is waiting, the response carries `rd_valid` = 1 and the oldest stored byte. Bytes come out in capture order, and both indices wrap modulo 2^PTR_W, so a stream longer than the buffer keeps flowing.
- R5: There is no flow control. If exactly 2^PTR_W bytes are stored while none is read, the buffer then reports no data.
- R6: While the recorded base is zero, reads cause no bus-master transaction.
- R7: With a nonzero base, each read that returns data is followed by a write transaction. The write has `mst_we` = 1, address `base - 1`, and data equal to the new read index (the count of bytes taken, modulo 2^PTR_W).
- R8: Reads that occur while a write-back is outstanding are merged. Once the bus is idle, the target byte holds the latest read index, and fewer writes than reads may be issued.
- R9: A pulse on `init_req` performs two transactions. First it reads from `init_base - 2`. Then it writes the returned byte to `init_base - 1`. After that, `init_base` becomes the recorded base. The local read index is not changed by this.
- R10: Target addresses are computed modulo 2^TA_W. For example, a base of 1 reads from the all-ones address and writes to address 0.
- R11: While `mst_req` is high and `mst_done` is low, `mst_req`, `mst_we`, `mst_addr` and `mst_wdata` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_sel_n | input | 1 | Asynchronous active-low select of the capture port |
| io_data | input | DW | Processor data bus |
| rd_req | input | 1 | Request to take the next byte |
| rd_done | output | 1 | Response strobe, one cycle after a request |
| rd_valid | output | 1 | Response carries a byte |
| rd_data | output | DW | Byte taken, meaningful when rd_valid is high |
| init_req | input | 1 | Start index synchronisation with init_base |
| init_base | input | TA_W | Header base address in target memory |
| mst_req | output | 1 | Bus-master transaction request |
| mst_we | output | 1 | 1 = write, 0 = read |
| mst_addr | output | TA_W | Target address |
| mst_wdata | output | DW | Write data |
| mst_rdata | input | DW | Read data, valid with mst_done |
| mst_done | input | 1 | Transaction complete, one cycle |

## Verification
The bench builds the block with its defaults: an 8-bit index, which gives a 256-byte buffer, and a 16-bit target address. With only 256 entries, both the index wrap and the full-buffer overrun can be reached in a few thousand cycles. The 16-bit address lets a base of 1 exercise address wrap below zero. The bench's bus-master model has a latency that can be changed, which exposes both one-write-per-read behaviour and the merging of write-backs.

// File: rtl/iomsg_pkg.sv
package iomsg_pkg;
  typedef enum logic [1:0] {
    MS_IDLE,
    MS_FETCH,
    MS_STORE,
    MS_MIRROR
  } mstate_e;
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sel_n_async,
  output logic fall
);
  localparam int LAST = STAGES;

  logic [LAST:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '1;
    else     sh <= {sh[LAST-1:0], sel_n_async};
  end

  assign fall = sh[LAST] & ~sh[LAST-1];

  // R2
  one_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    fall |=> !fall);
endmodule

// File: rtl/capture_mem.sv
module capture_mem #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/mirror_ctrl.sv
module mirror_ctrl
  import iomsg_pkg::*;
#(
  parameter int PTR_W = 8,
  parameter int DW    = 8,
  parameter int TA_W  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             init_req,
  input  logic [TA_W-1:0]  init_base,
  input  logic [PTR_W-1:0] cnt,
  input  logic             bump,
  output logic             mst_req,
  output logic             mst_we,
  output logic [TA_W-1:0]  mst_addr,
  output logic [DW-1:0]    mst_wdata,
  input  logic [DW-1:0]    mst_rdata,
  input  logic             mst_done
);
  localparam logic [TA_W-1:0] OFS_IN  = TA_W'(2);
  localparam logic [TA_W-1:0] OFS_OUT = TA_W'(1);

  mstate_e         state;
  logic [TA_W-1:0] base_q;
  logic [TA_W-1:0] pend_q;
  logic            dirty;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= MS_IDLE;
      base_q    <= '0;
      pend_q    <= '0;
      dirty     <= 1'b0;
      mst_req   <= 1'b0;
      mst_we    <= 1'b0;
      mst_addr  <= '0;
      mst_wdata <= '0;
    end else begin
      if (bump) dirty <= 1'b1;
      case (state)
        MS_IDLE: begin
          if (init_req) begin
            pend_q   <= init_base;
            mst_addr <= init_base - OFS_IN;
            mst_we   <= 1'b0;
            mst_req  <= 1'b1;
            state    <= MS_FETCH;
          end else if (dirty) begin
            if (base_q != '0) begin
              mst_addr  <= base_q - OFS_OUT;
              mst_we    <= 1'b1;
              mst_wdata <= DW'(cnt);
              mst_req   <= 1'b1;
              state     <= MS_MIRROR;
            end
            dirty <= bump;
          end
        end
        MS_FETCH: begin
          if (mst_done) begin
            mst_addr  <= pend_q - OFS_OUT;
            mst_we    <= 1'b1;
            mst_wdata <= mst_rdata;
            state     <= MS_STORE;
          end
        end
        MS_STORE: begin
          if (mst_done) begin
            base_q  <= pend_q;
            mst_req <= 1'b0;
            mst_we  <= 1'b0;
            state   <= MS_IDLE;
          end
        end
        default: begin
          if (mst_done) begin
            mst_req <= 1'b0;
            mst_we  <= 1'b0;
            state   <= MS_IDLE;
          end
        end
      endcase
    end
  end

  // R11
  hold_fields_chk: assert property (@(posedge clk) disable iff (rst)
    (mst_req && !mst_done) |=> (mst_req && $stable(mst_we) &&
                                $stable(mst_addr) && $stable(mst_wdata)));

  // R6
  no_zero_base_write_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(mst_req) && mst_we) |-> (base_q != '0));

  // R9
  init_starts_read_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(mst_req) && $past(init_req)) |-> !mst_we);
endmodule

// File: rtl/iostrobe_msgbuf.sv
module iostrobe_msgbuf #(
  parameter int DW          = 8,
  parameter int PTR_W       = 8,
  parameter int TA_W        = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            io_sel_n,
  input  logic [DW-1:0]   io_data,
  input  logic            rd_req,
  output logic            rd_done,
  output logic            rd_valid,
  output logic [DW-1:0]   rd_data,
  input  logic            init_req,
  input  logic [TA_W-1:0] init_base,
  output logic            mst_req,
  output logic            mst_we,
  output logic [TA_W-1:0] mst_addr,
  output logic [DW-1:0]   mst_wdata,
  input  logic [DW-1:0]   mst_rdata,
  input  logic            mst_done
);
  localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

  logic             cap_fall;
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_cnt;
  logic             avail;
  logic             take;

  strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk         (clk),
    .rst         (rst),
    .sel_n_async (io_sel_n),
    .fall        (cap_fall)
  );

  assign avail = (wr_ptr != rd_cnt);
  assign take  = rd_req & avail;

  capture_mem #(.AW(PTR_W), .DW(DW)) u_mem (
    .clk   (clk),
    .we    (cap_fall),
    .waddr (wr_ptr),
    .wdata (io_data),
    .re    (take),
    .raddr (rd_cnt),
    .rdata (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr   <= '0;
      rd_cnt   <= '0;
      rd_done  <= 1'b0;
      rd_valid <= 1'b0;
    end else begin
      if (cap_fall) wr_ptr <= wr_ptr + ONE;
      if (take)     rd_cnt <= rd_cnt + ONE;
      rd_done  <= rd_req;
      rd_valid <= take;
    end
  end

  mirror_ctrl #(.PTR_W(PTR_W), .DW(DW), .TA_W(TA_W)) u_mirror (
    .clk       (clk),
    .rst       (rst),
    .init_req  (init_req),
    .init_base (init_base),
    .cnt       (rd_cnt),
    .bump      (take),
    .mst_req   (mst_req),
    .mst_we    (mst_we),
    .mst_addr  (mst_addr),
    .mst_wdata (mst_wdata),
    .mst_rdata (mst_rdata),
    .mst_done  (mst_done)
  );

  // R3
  done_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    rd_done |-> $past(rd_req));

  // R3
  valid_needs_done_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> rd_done);

  // R4
  index_step_chk: assert property (@(posedge clk) disable iff (rst)
    rd_done |-> (rd_cnt == $past(rd_cnt) + PTR_W'(rd_valid)));
endmodule

// File: tb/iostrobe_msgbuf_tb.sv
module iostrobe_msgbuf_tb;
  localparam int DW = 8;
  localparam int PTR_W = 8;
  localparam int TA_W = 16;
  localparam int DEPTH = 1 << PTR_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic io_sel_n = 1'b1;
  logic [DW-1:0] io_data = '0;
  logic rd_req = 1'b0;
  logic rd_done, rd_valid;
  logic [DW-1:0] rd_data;
  logic init_req = 1'b0;
  logic [TA_W-1:0] init_base = '0;
  logic mst_req, mst_we;
  logic [TA_W-1:0] mst_addr;
  logic [DW-1:0] mst_wdata;
  logic [DW-1:0] mst_rdata = '0;
  logic mst_done = 1'b0;

  always #10 clk = ~clk;

  iostrobe_msgbuf #(.DW(DW), .PTR_W(PTR_W), .TA_W(TA_W)) u_dut (
    .clk(clk), .rst(rst), .io_sel_n(io_sel_n), .io_data(io_data),
    .rd_req(rd_req), .rd_done(rd_done), .rd_valid(rd_valid), .rd_data(rd_data),
    .init_req(init_req), .init_base(init_base),
    .mst_req(mst_req), .mst_we(mst_we), .mst_addr(mst_addr),
    .mst_wdata(mst_wdata), .mst_rdata(mst_rdata), .mst_done(mst_done)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [7:0] mq[$];
  int model_rd = 0;
  logic [7:0] tmem [int];

  int mlat = 2;
  bit busy = 0;
  int wcnt = 0;
  bit cur_we;
  int cur_a;
  logic [7:0] cur_d;
  int n_tx = 0;
  int n_wr = 0;
  int last_rd_addr = -1;
  int last_wr_addr = -1;
  int last_wr_data = -1;
  bit req_seen = 0;
  bit last_valid = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] tget(input int a);
    if (tmem.exists(a)) return tmem[a];
    return 8'h00;
  endfunction

  // reference model, compared on every clock; bus-master model
  always @(negedge clk) begin
    if (rst) begin
      req_seen = 0;
      busy = 0;
      mst_done = 1'b0;
    end else begin
      bit just;
      if (req_seen) begin
        chk(rd_done == 1'b1, "R3 response strobe", int'(rd_done), 1);
        if (mq.size() > 0) begin
          chk(rd_valid == 1'b1 && rd_data == mq[0], "R4 oldest byte",
              int'({rd_valid, rd_data}), int'({1'b1, mq[0]}));
          void'(mq.pop_front());
          model_rd = (model_rd + 1) % DEPTH;
        end else begin
          chk(rd_valid == 1'b0, "R3 empty read", int'(rd_valid), 0);
        end
        last_valid = rd_valid;
      end else begin
        chk(rd_done == 1'b0, "R3 no spurious strobe", int'(rd_done), 0);
      end
      req_seen = rd_req;

      just = mst_done;
      mst_done = 1'b0;
      if (busy) begin
        wcnt--;
        if (wcnt == 0) begin
          if (cur_we) begin
            tmem[cur_a] = cur_d;
            n_wr++;
            last_wr_addr = cur_a;
            last_wr_data = int'(cur_d);
          end else begin
            mst_rdata = tget(cur_a);
            last_rd_addr = cur_a;
          end
          n_tx++;
          mst_done = 1'b1;
          busy = 0;
        end
      end else if (mst_req && !just) begin
        busy = 1;
        wcnt = mlat;
        cur_we = mst_we;
        cur_a = int'(mst_addr);
        cur_d = mst_wdata;
      end
    end
  end

  task automatic capture(input logic [7:0] b, input int low_cycles);
    @(posedge clk); #2;
    io_data = b;
    io_sel_n = 1'b0;
    repeat (low_cycles) @(posedge clk);
    #2 io_sel_n = 1'b1;
    repeat (4) @(posedge clk);
    mq.push_back(b);
    if (mq.size() == DEPTH) mq.delete();
  endtask

  task automatic read1();
    @(posedge clk); #2 rd_req = 1'b1;
    @(posedge clk); #2 rd_req = 1'b0;
    repeat (2) @(posedge clk);
  endtask

  task automatic settle();
    repeat (6 * mlat + 20) @(posedge clk);
  endtask

  task automatic do_init(input logic [TA_W-1:0] b);
    @(posedge clk); #2 init_req = 1'b1; init_base = b;
    @(posedge clk); #2 init_req = 1'b0;
    settle();
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int tx0;
    int wr0;
    repeat (4) @(posedge clk);
    #2 rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(rd_done == 1'b0, "R1 rd_done after reset", int'(rd_done), 0);
    chk(mst_req == 1'b0, "R1 mst_req after reset", int'(mst_req), 0);
    read1();
    chk(last_valid == 1'b0, "R1 first read empty", int'(last_valid), 0);

    // R2 / R4 basic ordering, base zero so no target traffic (R6)
    tx0 = n_tx;
    capture(8'hA5, 4);
    capture(8'h3C, 4);
    capture(8'h7E, 4);
    read1(); read1(); read1();
    chk(last_valid == 1'b1, "R4 third byte valid", int'(last_valid), 1);
    read1();
    chk(last_valid == 1'b0, "R3 drained", int'(last_valid), 0);

    // R2 held-low select stores one byte
    capture(8'h42, 40);
    read1();
    chk(last_valid == 1'b1, "R2 held select stored", int'(last_valid), 1);
    read1();
    chk(last_valid == 1'b0, "R2 held select stored once", int'(last_valid), 0);
    settle();
    chk(n_tx == tx0, "R6 no access with zero base", n_tx, tx0);

    // R9 initialisation
    tmem[16'h00FE] = 8'h37;
    do_init(16'h0100);
    chk(last_rd_addr == 16'h00FE, "R9 read address", last_rd_addr, 16'h00FE);
    chk(tget(16'h00FF) == 8'h37, "R9 copied index", int'(tget(16'h00FF)), 8'h37);
    capture(8'h11, 4);
    read1();
    chk(last_valid == 1'b1, "R9 local index kept", int'(last_valid), 1);
    settle();
    // R7 write-back
    chk(last_wr_addr == 16'h00FF, "R7 write address", last_wr_addr, 16'h00FF);
    chk(int'(tget(16'h00FF)) == model_rd, "R7 written index", int'(tget(16'h00FF)), model_rd);

    // R8 merged write-backs
    mlat = 30;
    capture(8'h01, 4); capture(8'h02, 4); capture(8'h03, 4); capture(8'h04, 4);
    wr0 = n_wr;
    read1(); read1(); read1(); read1();
    settle();
    chk(int'(tget(16'h00FF)) == model_rd, "R8 final index", int'(tget(16'h00FF)), model_rd);
    chk(n_wr - wr0 < 4, "R8 writes merged", n_wr - wr0, 3);
    chk(last_wr_data == model_rd, "R8 last write data", last_wr_data, model_rd);
    mlat = 2;

    // R4 wrap of indices
    for (int i = 0; i < 250; i++) capture(8'(i * 7 + 3), 4);
    for (int i = 0; i < 250; i++) read1();
    settle();
    chk(mq.size() == 0, "R4 wrap drained", mq.size(), 0);
    chk(int'(tget(16'h00FF)) == model_rd, "R7 index after wrap", int'(tget(16'h00FF)), model_rd);

    // R5 overrun by a full buffer
    for (int i = 0; i < DEPTH; i++) capture(8'(i ^ 8'h5A), 4);
    read1();
    chk(last_valid == 1'b0, "R5 full overrun looks empty", int'(last_valid), 0);
    capture(8'hC3, 4);
    read1();
    chk(last_valid == 1'b1, "R5 resumes after overrun", int'(last_valid), 1);
    settle();

    // R10 address wrap
    tmem[16'hFFFF] = 8'h5A;
    do_init(16'h0001);
    chk(last_rd_addr == 16'hFFFF, "R10 read address wraps", last_rd_addr, 16'hFFFF);
    chk(tget(16'h0000) == 8'h5A, "R10 write address wraps", int'(tget(16'h0000)), 8'h5A);
    capture(8'h99, 4);
    read1();
    settle();
    chk(int'(tget(16'h0000)) == model_rd, "R10 write-back at wrapped address",
        int'(tget(16'h0000)), model_rd);
    // R11 handshake stability is covered by hold_fields_chk in the RTL
    chk(mst_req == 1'b0, "R11 bus idle at end", int'(mst_req), 0);

    summary();
  end
endmodule